// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of general-purpose I/O pins behind a simple 32-bit register bus with an address, a write enable, write data and combinational read data. Seven per-pin configuration registers (output data, interrupt mask, pull disable, function, select, direction, trigger) can each be written whole, or changed bit by bit through a write-one-to-set alias and a write-one-to-clear alias. The pad inputs are synchronized and can be read back as a level register.

The same configuration bits serve both plain I/O and interrupt setup. A pin with select set and function clear is an interrupt source. Its trigger bit picks edge or level detection, and its direction bit picks the polarity. Detected events latch in a flag register. A registered interrupt output is raised while any flag is pending on a pin whose mask bit is clear. Pins with function set are handed to an alternate peripheral, which the bank reports only as a per-pin two-bit code. The number of implemented pins is a parameter. Register bits above that count are tied to zero.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration register and the flag register read zero, except the mask register, which reads one on every implemented bit. The interrupt output is low.
- R2: A write to a register's base offset (data 0x10, mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60, trigger 0x70) replaces its contents and is readable at the same offset on the next cycle. Writes to the level offset 0x00 and the flag offset 0x80 change nothing.
- R3: A write to base+0x4 sets exactly the bits written as one and leaves the others unchanged.
- R4: A write to base+0x8 clears exactly the bits written as one and leaves the others unchanged.
- R5: Bits at and above NUM_PINS read as zero in every register, and the matching outputs stay low whatever is written or applied at the pin inputs.
- R6: Offset 0x00 returns the pin inputs delayed by a two-flop synchronizer. A change applied before a rising edge shows up after the second rising edge.
- R7: When function and select are both clear, a set direction bit drives pin_oe_o high and pin_o carries the data bit. Otherwise pin_oe_o is low.
- R8: pull_en_o is high exactly where the pull bit is clear.
- R9: func_sel_o holds two bits per pin (pin n at bits 2n+1:2n). The code is 0 with function clear, 1 with function set and select clear, 2 with function and select set and trigger clear, and 3 with all three set.
- R10: A pin with select set and function clear latches its flag bit (offset 0x80) on the following event. With trigger=1 the event is a rising edge (direction=1) or a falling edge (direction=0) of the synchronized input. With trigger=0 it is a high level (direction=1) or a low level (direction=0). A pin with function set never latches a flag.
- R11: A write to 0x14 clears the flag bits written as one and also sets the same data bits. A condition still present in that cycle keeps its flag set.
- R12: Flags latch regardless of the mask. irq_o is high one cycle after any flag bit is set while its mask bit is clear, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| pin_i | input | DATA_W | Pad input levels |
| pin_o | output | DATA_W | Output data to pads |
| pin_oe_o | output | DATA_W | Pad output enable |
| pull_en_o | output | DATA_W | Pull-up enable per pin |
| func_sel_o | output | 2*DATA_W | Per-pin function code |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the bank with NUM_PINS=31 on a 32-bit bus, so the top bit is unimplemented. This lets it check that bit 31 stays zero under random set, clear and plain writes, and that a toggling input on that pin is never seen. A seeded random phase exercises all three access views of every register against a bench model. Directed sequences then cover each of the four detection modes, the masked case, a flag clear while a level is still held, a pin blocked by its function bit, and the shared data-set/flag-clear address.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_CFG = 7;
  // cfg index order; base offset = 0x10 * (index + 1)
  localparam int IDX_DATA = 0;
  localparam int IDX_MASK = 1;
  localparam int IDX_PULL = 2;
  localparam int IDX_FUNC = 3;
  localparam int IDX_SEL  = 4;
  localparam int IDX_DIR  = 5;
  localparam int IDX_TRIG = 6;

  localparam logic [7:0] OFF_LEVEL = 8'h00;
  localparam logic [7:0] OFF_FLAG  = 8'h80;
  localparam logic [7:0] ALIAS_SET = 8'h04;
  localparam logic [7:0] ALIAS_CLR = 8'h08;
  localparam logic [7:0] OFF_FLAG_CLR = 8'h14;

  function automatic logic [7:0] cfg_base(input int idx);
    return 8'((idx + 1) * 16);
  endfunction

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_ALT1 = 2'd1,
    FN_ALT2 = 2'd2,
    FN_ALT3 = 2'd3
  } fn_code_e;
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] wmask;
  assign wmask = wdata_i & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL & IMPL_MASK;
    else if (wr_i)  q_o <= wmask;
    else if (set_i) q_o <= q_o | wmask;
    else if (clr_i) q_o <= q_o & ~wmask;
  end

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(wmask)) == $past(wmask)) && ((q_o & ~$past(wmask)) == ($past(q_o) & ~$past(wmask))));
  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(wmask)) == '0) && ((q_o & ~$past(wmask)) == ($past(q_o) & ~$past(wmask))));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] lvl_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] trig_i,
  input  logic [DATA_W-1:0] dir_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              flag_clr_i,
  input  logic [DATA_W-1:0] clr_bits_i,
  output logic [DATA_W-1:0] flag_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] prev_q, rise, fall, hit, clr_vec;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      if (trig_i[i]) hit[i] = dir_i[i] ? rise[i] : fall[i];
      else           hit[i] = dir_i[i] ? lvl_i[i] : ~lvl_i[i];
    end
    hit     = hit & src_i & IMPL_MASK;
    clr_vec = flag_clr_i ? clr_bits_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_o <= (flag_o & ~clr_vec) | hit; // a live condition wins over a clear
      irq_o  <= |(flag_o & ~mask_i);
    end
  end

  p_flag_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_o & ~$past(flag_o)) & ~$past(src_i)) == '0);
  p_irq_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(flag_o & ~mask_i)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [DATA_W-1:0]   pin_i,
  output logic [DATA_W-1:0]   pin_o,
  output logic [DATA_W-1:0]   pin_oe_o,
  output logic [DATA_W-1:0]   pull_en_o,
  output logic [2*DATA_W-1:0] func_sel_o,
  output logic                irq_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK = {DATA_W{1'b1}} >> (DATA_W - NUM_PINS);

  logic [DATA_W-1:0] cfg_q [NUM_CFG];
  logic [DATA_W-1:0] lvl, flag;
  logic [NUM_CFG-1:0] wr_en, set_en, clr_en;
  logic flag_clr;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    assign wr_en[g]  = we_i && (addr_i == ADDR_W'(cfg_base(g)));
    assign set_en[g] = we_i && (addr_i == ADDR_W'(cfg_base(g) + ALIAS_SET));
    assign clr_en[g] = we_i && (addr_i == ADDR_W'(cfg_base(g) + ALIAS_CLR));
    gpio_cfg_reg #(
      .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK),
      .RST_VAL((g == IDX_MASK) ? {DATA_W{1'b1}} : {DATA_W{1'b0}})
    ) u_reg (
      .clk_i, .rst_ni,
      .wr_i(wr_en[g]), .set_i(set_en[g]), .clr_i(clr_en[g]),
      .wdata_i, .q_o(cfg_q[g])
    );
  end

  // flag clear shares its address with the data-set alias
  assign flag_clr = we_i && (addr_i == ADDR_W'(OFF_FLAG_CLR));

  gpio_sync #(.DATA_W(DATA_W)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i & IMPL_MASK), .q_o(lvl)
  );

  gpio_irq_detect #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_det (
    .clk_i, .rst_ni,
    .lvl_i(lvl),
    .src_i(cfg_q[IDX_SEL] & ~cfg_q[IDX_FUNC]),
    .trig_i(cfg_q[IDX_TRIG]),
    .dir_i(cfg_q[IDX_DIR]),
    .mask_i(cfg_q[IDX_MASK]),
    .flag_clr_i(flag_clr),
    .clr_bits_i(wdata_i),
    .flag_o(flag),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_LEVEL))     rdata_o = lvl;
    else if (addr_i == ADDR_W'(OFF_FLAG)) rdata_o = flag;
    else
      for (int i = 0; i < NUM_CFG; i++)
        if (addr_i == ADDR_W'(cfg_base(i))) rdata_o = cfg_q[i];
  end

  assign pin_o     = cfg_q[IDX_DATA];
  assign pin_oe_o  = cfg_q[IDX_DIR] & ~cfg_q[IDX_FUNC] & ~cfg_q[IDX_SEL];
  assign pull_en_o = ~cfg_q[IDX_PULL] & IMPL_MASK;

  for (genvar p = 0; p < DATA_W; p++) begin : g_fn
    fn_code_e code;
    always_comb begin
      if (!cfg_q[IDX_FUNC][p])     code = FN_GPIO;
      else if (!cfg_q[IDX_SEL][p]) code = FN_ALT1;
      else if (!cfg_q[IDX_TRIG][p]) code = FN_ALT2;
      else                          code = FN_ALT3;
    end
    assign func_sel_o[2*p +: 2] = code;
  end

  p_unimpl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o | pin_o | pin_oe_o | pull_en_o) & ~IMPL_MASK) == '0);
  p_oe_plain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & rdata_o & {DATA_W{addr_i == ADDR_W'(cfg_base(IDX_SEL))}}) == '0);
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 31;
  localparam logic [31:0] IMPL = 32'h7FFF_FFFF;

  logic clk = 0, rst_ni = 0, we = 0, irq;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, pin = '0, pout, poe, pull_en;
  logic [63:0] fsel;
  int n_chk = 0, n_fail = 0;
  logic [31:0] m [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.DATA_W(32), .ADDR_W(8), .NUM_PINS(NP)) u0 (
    .clk_i(clk), .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pout), .pin_oe_o(poe),
    .pull_en_o(pull_en), .func_sel_o(fsel), .irq_o(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] model_op(input logic [31:0] cur, input int kind, input logic [31:0] d);
    case (kind)
      0: return d & IMPL;
      1: return cur | (d & IMPL);
      default: return cur & ~d & IMPL;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    idle(2); rst_ni = 1; idle(1);
    // R1 reset state
    for (int i = 0; i < 7; i++) rchk("R1", 8'((i + 1) * 16), (i == 1) ? IMPL : 32'h0);
    rchk("R1", 8'h80, 32'h0);
    chk("R1", irq, 1'b0);

    // random register accesses; pins held low, flags not inspected here
    for (int i = 0; i < 7; i++) m[i] = (i == 1) ? IMPL : 32'h0;
    for (int t = 0; t < 300; t++) begin
      int idx = int'($urandom_range(0, 6));
      int kind = int'($urandom_range(0, 3));
      logic [31:0] dv = $urandom();
      if (kind == 3) begin
        wr(($urandom_range(0, 1) != 0) ? 8'h00 : 8'h80, dv); // R2 ignored offsets
      end else begin
        wr(8'((idx + 1) * 16 + kind * 4), dv);
        m[idx] = model_op(m[idx], kind, dv);
        if (idx == 0 && kind == 1) ; // data-set alias also clears flags
      end
      for (int i = 0; i < 7; i++)
        rchk((kind == 0) ? "R2" : (kind == 1) ? "R3" : (kind == 2) ? "R4" : "R2 R5",
             8'((i + 1) * 16), m[i]);
      chk("R8 R5", pull_en, ~m[2] & IMPL);
      chk("R7 R5", {pout, poe}, {m[0], m[5] & ~m[3] & ~m[4]});
    end

    // clean up: sources off before flags cleared
    wr(8'h50, 0); wr(8'h40, 0); wr(8'h70, 0); wr(8'h60, 0); wr(8'h30, 0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h10, 0);
    rchk("R11", 8'h80, 32'h0);
    rchk("R5", 8'h10, 32'h0);
    idle(2); chk("R12", irq, 1'b0);

    // R6 synchronizer latency
    @(negedge clk); pin = 32'h00A5_0000;
    @(negedge clk); rchk("R6", 8'h00, 32'h0);
    @(negedge clk); rchk("R6", 8'h00, 32'h00A5_0000);
    pin = 32'h8000_0000; idle(3);
    rchk("R5", 8'h00, 32'h0);
    wr(8'h64, 32'hFFFF_FFFF); rchk("R5", 8'h60, IMPL); chk("R5", poe[31], 1'b0);
    wr(8'h60, 0); pin = 0; idle(3);

    // R7 plain output
    wr(8'h60, 32'h9); wr(8'h10, 32'h8);
    chk("R7", {pout, poe}, {32'h8, 32'h9});
    wr(8'h54, 32'h1); chk("R7", poe, 32'h8);
    wr(8'h58, 32'h1); wr(8'h60, 0); wr(8'h10, 0);
    // R8 pull
    wr(8'h34, 32'h5); chk("R8", pull_en, IMPL & ~32'h5); wr(8'h30, 0);

    // R9 function codes, pins 0..3
    wr(8'h44, 32'h7); wr(8'h74, 32'h4); wr(8'h54, 32'h6);
    chk("R9", fsel[7:0], 8'h39);
    wr(8'h58, 32'h6); wr(8'h70, 0); wr(8'h40, 0);
    chk("R9", fsel, 64'h0);
    rchk("R10", 8'h80, 32'h0);

    // R10 rising edge pin 5, unmasked
    wr(8'h64, 32'h20); wr(8'h74, 32'h20); wr(8'h54, 32'h20); wr(8'h28, 32'h20);
    idle(3); rchk("R10", 8'h80, 32'h0);
    pin[5] = 1; idle(5);
    rchk("R10", 8'h80, 32'h20);
    chk("R12", irq, 1'b1);
    wr(8'h14, 32'h20);
    rchk("R11", 8'h80, 32'h0);
    rchk("R11", 8'h10, 32'h20);
    idle(1); chk("R12", irq, 1'b0);
    idle(4); rchk("R10", 8'h80, 32'h0); // held high: no new edge

    // R10 falling edge pin 6, masked
    pin[6] = 1; idle(5);
    wr(8'h74, 32'h40); wr(8'h54, 32'h40);
    pin[6] = 0; idle(5);
    rchk("R10", 8'h80, 32'h40);
    chk("R12", irq, 1'b0);
    wr(8'h28, 32'h40); idle(1);
    chk("R12", irq, 1'b1);
    wr(8'h24, 32'h40); wr(8'h14, 32'h40); idle(2);
    chk("R12", irq, 1'b0);

    // R10 level high pin 7; R11 clear while held
    wr(8'h64, 32'h80); wr(8'h54, 32'h80);
    rchk("R10", 8'h80, 32'h0);
    pin[7] = 1; idle(5);
    rchk("R10", 8'h80, 32'h80);
    wr(8'h14, 32'h80); idle(1);
    rchk("R11", 8'h80, 32'h80);
    pin[7] = 0; idle(4);
    wr(8'h14, 32'h80);
    rchk("R11", 8'h80, 32'h0);

    // R10 level low pin 9 triggers immediately with pin low
    wr(8'h54, 32'h200); idle(4);
    rchk("R10", 8'h80, 32'h200);
    wr(8'h58, 32'h200); wr(8'h14, 32'h200);
    rchk("R10", 8'h80, 32'h0);

    // R10 function bit blocks pin 8
    wr(8'h44, 32'h100); wr(8'h64, 32'h100); wr(8'h54, 32'h100);
    pin[8] = 1; idle(5);
    rchk("R10", 8'h80, 32'h0);
    chk("R9", fsel[17:16], 2'd2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule